// File: doc/BRIEF.md
# Two-Slot Outbound Request Controller

The controller sits between an upstream receive command queue and a downstream bus master. It holds at most two outbound requests at a time. Each request carries an address, a byte length and a posted flag. The controller hands each request to the bus master through a registered issue port. It watches per-slot status reports from the master, and reissues a request that was retried or cut short by a disconnect. A disconnected request resumes from the point where the transfer stopped.

Requests that expect an answer (non-posted) need space in a two-entry response data buffer. Only one of those entries may ever go to non-posted traffic; the other stays reserved for posted traffic, so a stalled read can never hold up a write. When a non-posted request completes at its destination, its slot is retired at once. The controller then raises a one-cycle response-needed pulse, but the buffer entry stays held until the response has gone out on the transmit side. A per-slot retry timer with a programmable limit bounds how long a request may stay in flight. The two slots give no ordering guarantee between them; any ordering must be enforced upstream.

Top module: `outreq_ctrl`

## Requirements
- R1: After reset no slot is busy, `iss_valid`, `rsp_need` and `err_valid` are low, and `in_ready` is high. A new request always goes to the lowest-numbered free slot, and `in_ready` is low while both slots are busy.
- R2: A request accepted into a slot is presented on the issue port. `iss_valid`, `iss_slot`, `iss_addr`, `iss_len` and `iss_posted` hold steady until `iss_take`. The cycle after a take, `iss_valid` is low.
- R3: When both slots wait to be issued, the slot chosen is the one other than the slot issued last. When only one slot waits, it is issued directly. The first issue after reset, with both waiting, goes to slot 0.
- R4: A request with `in_posted`=0 is accepted only while no non-posted request holds the response entry. Posted requests are accepted regardless of that entry.
- R5: Status kind 2'b01 (retry) on an in-flight slot makes it issue again with unchanged address and length.
- R6: Status kind 2'b10 (disconnect) on an in-flight slot makes it issue again with the address raised by the moved count and the length lowered by it.
- R7: Status kind 2'b00 (complete) on an in-flight posted slot frees the slot and produces no `rsp_need`.
- R8: Complete on an in-flight non-posted slot frees the slot and pulses `rsp_need` for one cycle, one cycle later, with `rsp_slot` naming the slot. The response entry stays held until a `rsp_done` pulse.
- R9: A slot's timer starts at its first take and is not restarted by reissue. Exactly `tmr_limit`+1 cycles after that take edge, if the slot has not completed, `err_valid` pulses with the slot's bit set in `err_mask`. The slot is freed, and any response entry the slot holds is released.
- R10: Status on a slot that is not in flight is ignored, and so is status kind 2'b11. A `rsp_done` while no response is owed is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream request valid |
| in_ready | output | 1 | Controller can take the request |
| in_addr | input | ADDR_W | Request start address |
| in_len | input | LEN_W | Request length in bytes |
| in_posted | input | 1 | 1 = posted, 0 = needs a response |
| iss_valid | output | 1 | Issue port holds a request |
| iss_take | input | 1 | Bus master takes the issued request |
| iss_slot | output | 1 | Slot of the issued request |
| iss_addr | output | ADDR_W | Issued address |
| iss_len | output | LEN_W | Issued length |
| iss_posted | output | 1 | Issued posted flag |
| st_valid | input | 2 | Per-slot status strobe |
| st_kind | input | 4 | Per-slot 2-bit status kind, slot s at bits [2s+1:2s] |
| st_moved | input | 2*LEN_W | Per-slot bytes moved before a disconnect |
| tmr_limit | input | TMR_W | Retry timer limit in cycles |
| rsp_need | output | 1 | One-cycle pulse: a response must be generated |
| rsp_slot | output | 1 | Slot that needs the response |
| rsp_done | input | 1 | The response has been issued; release the entry |
| err_valid | output | 1 | One-cycle pulse: a retry timer expired |
| err_mask | output | 2 | Slots whose timer expired |

## Verification
A slot stuck in the wrong state shows up within a few cycles: `in_ready` no longer matches the count of live slots, or an expected reissue never appears on the issue port. Corrupted resume arithmetic is visible on the next issue of that slot, as a wrong `iss_addr` or `iss_len`. A wrong round-robin pointer shows as the wrong slot issued first after a double retry. A lost or stuck response-entry flag shows as `in_ready` being wrong for a non-posted request, in the cycle right after `rsp_done` or a timer expiry.

// File: rtl/outreq_pkg.sv
package outreq_pkg;
  localparam int NSLOT  = 2;
  localparam int SLOT_W = 1;

  typedef enum logic [1:0] {
    SL_FREE = 2'd0,
    SL_PEND = 2'd1,
    SL_OUT  = 2'd2,
    SL_WAIT = 2'd3
  } slot_st_t;

  typedef enum logic [1:0] {
    ST_DONE  = 2'b00,
    ST_RETRY = 2'b01,
    ST_DISC  = 2'b10,
    ST_RSVD  = 2'b11
  } st_kind_t;
endpackage

// File: rtl/outreq_slot.sv
module outreq_slot
  import outreq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 12,
  parameter int TMR_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [LEN_W-1:0]  a_len,
  input  logic              a_posted,
  input  logic              load,
  input  logic              take,
  input  logic              st_hit,
  input  logic [1:0]        st_kind,
  input  logic [LEN_W-1:0]  st_moved,
  input  logic [TMR_W-1:0]  lim,
  output slot_st_t          state,
  output logic [ADDR_W-1:0] addr,
  output logic [LEN_W-1:0]  len,
  output logic              posted,
  output logic              pend,
  output logic              fin,
  output logic              expire
);
  logic [TMR_W-1:0] tmr;
  logic             started;
  logic             hit_ok;

  always_comb begin
    hit_ok = st_hit && (state == SL_WAIT) && (st_kind != ST_RSVD);
    fin    = hit_ok && (st_kind == ST_DONE);
    expire = started && (tmr >= lim) &&
             ((state == SL_PEND) || ((state == SL_WAIT) && !hit_ok));
    pend   = (state == SL_PEND) && !expire;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SL_FREE;
      started <= 1'b0;
      tmr     <= '0;
      addr    <= '0;
      len     <= '0;
      posted  <= 1'b0;
    end else begin
      if (started && (tmr != '1)) tmr <= tmr + 1'b1;
      case (state)
        SL_FREE: begin
          if (alloc) begin
            addr    <= a_addr;
            len     <= a_len;
            posted  <= a_posted;
            started <= 1'b0;
            state   <= SL_PEND;
          end
        end
        SL_PEND: begin
          if (expire) begin
            state   <= SL_FREE;
            started <= 1'b0;
          end else if (load) begin
            state <= SL_OUT;
          end
        end
        SL_OUT: begin
          if (take) begin
            state <= SL_WAIT;
            if (!started) begin
              started <= 1'b1;
              tmr     <= '0;
            end
          end
        end
        SL_WAIT: begin
          if (expire) begin
            state   <= SL_FREE;
            started <= 1'b0;
          end else if (hit_ok) begin
            case (st_kind)
              ST_DONE: begin
                state   <= SL_FREE;
                started <= 1'b0;
              end
              ST_DISC: begin
                addr  <= addr + ADDR_W'(st_moved);
                len   <= len - st_moved;
                state <= SL_PEND;
              end
              default: state <= SL_PEND;
            endcase
          end
        end
        default: state <= SL_FREE;
      endcase
    end
  end
endmodule

// File: rtl/outreq_arb.sv
module outreq_arb
  import outreq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [NSLOT-1:0] pend,
  input  logic             load_en,
  output logic             pick,
  output logic             any
);
  logic rr;

  always_comb begin
    any  = |pend;
    pick = (&pend) ? rr : pend[1];
  end

  always_ff @(posedge clk) begin
    if (rst) rr <= 1'b0;
    else if (load_en && any) rr <= ~pick;
  end
endmodule

// File: rtl/outreq_rbuf.sv
module outreq_rbuf
  import outreq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_np,
  input  logic             alloc_slot,
  input  logic [NSLOT-1:0] done_mask,
  input  logic [NSLOT-1:0] exp_mask,
  input  logic             rsp_done,
  output logic             np_busy
);
  logic inslot;
  logic held_slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      np_busy   <= 1'b0;
      inslot    <= 1'b0;
      held_slot <= 1'b0;
    end else if (alloc_np) begin
      np_busy   <= 1'b1;
      inslot    <= 1'b1;
      held_slot <= alloc_slot;
    end else begin
      if (inslot && done_mask[held_slot]) inslot <= 1'b0;
      if (inslot && exp_mask[held_slot]) begin
        inslot  <= 1'b0;
        np_busy <= 1'b0;
      end
      if (!inslot && np_busy && rsp_done) np_busy <= 1'b0;
    end
  end
endmodule

// File: rtl/outreq_ctrl.sv
module outreq_ctrl
  import outreq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 12,
  parameter int TMR_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [ADDR_W-1:0]      in_addr,
  input  logic [LEN_W-1:0]       in_len,
  input  logic                   in_posted,
  output logic                   iss_valid,
  input  logic                   iss_take,
  output logic [SLOT_W-1:0]      iss_slot,
  output logic [ADDR_W-1:0]      iss_addr,
  output logic [LEN_W-1:0]       iss_len,
  output logic                   iss_posted,
  input  logic [NSLOT-1:0]       st_valid,
  input  logic [2*NSLOT-1:0]     st_kind,
  input  logic [LEN_W*NSLOT-1:0] st_moved,
  input  logic [TMR_W-1:0]       tmr_limit,
  output logic                   rsp_need,
  output logic [SLOT_W-1:0]      rsp_slot,
  input  logic                   rsp_done,
  output logic                   err_valid,
  output logic [NSLOT-1:0]       err_mask
);
  slot_st_t          s_state [NSLOT];
  logic [ADDR_W-1:0] s_addr  [NSLOT];
  logic [LEN_W-1:0]  s_len   [NSLOT];
  logic [NSLOT-1:0]  s_posted, s_pend, s_fin, s_exp, s_free, s_busy, s_np_done;
  logic              np_busy, any_pend, pick, load_en, alloc_idx, acc;

  always_comb begin
    for (int s = 0; s < NSLOT; s++) s_free[s] = (s_state[s] == SL_FREE);
    s_busy    = ~s_free;
    s_np_done = s_fin & ~s_posted;
    alloc_idx = s_free[0] ? 1'b0 : 1'b1;
    in_ready  = (|s_free) && (in_posted || !np_busy);
    acc       = in_valid && in_ready;
    load_en   = !iss_valid;
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    outreq_slot #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .TMR_W(TMR_W)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .alloc    (acc && (alloc_idx == SLOT_W'(s))),
      .a_addr   (in_addr),
      .a_len    (in_len),
      .a_posted (in_posted),
      .load     (load_en && any_pend && (pick == SLOT_W'(s))),
      .take     (iss_valid && iss_take && (iss_slot == SLOT_W'(s))),
      .st_hit   (st_valid[s]),
      .st_kind  (st_kind[2*s +: 2]),
      .st_moved (st_moved[LEN_W*s +: LEN_W]),
      .lim      (tmr_limit),
      .state    (s_state[s]),
      .addr     (s_addr[s]),
      .len      (s_len[s]),
      .posted   (s_posted[s]),
      .pend     (s_pend[s]),
      .fin      (s_fin[s]),
      .expire   (s_exp[s])
    );
  end

  outreq_arb u_arb (
    .clk     (clk),
    .rst     (rst),
    .pend    (s_pend),
    .load_en (load_en),
    .pick    (pick),
    .any     (any_pend)
  );

  outreq_rbuf u_rbuf (
    .clk        (clk),
    .rst        (rst),
    .alloc_np   (acc && !in_posted),
    .alloc_slot (alloc_idx),
    .done_mask  (s_np_done),
    .exp_mask   (s_exp),
    .rsp_done   (rsp_done),
    .np_busy    (np_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_valid  <= 1'b0;
      iss_slot   <= '0;
      iss_addr   <= '0;
      iss_len    <= '0;
      iss_posted <= 1'b0;
    end else if (iss_valid && iss_take) begin
      iss_valid <= 1'b0;
    end else if (load_en && any_pend) begin
      iss_valid  <= 1'b1;
      iss_slot   <= pick;
      iss_addr   <= s_addr[pick];
      iss_len    <= s_len[pick];
      iss_posted <= s_posted[pick];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_need  <= 1'b0;
      rsp_slot  <= '0;
      err_valid <= 1'b0;
      err_mask  <= '0;
    end else begin
      rsp_need  <= |s_np_done;
      rsp_slot  <= s_np_done[1];
      err_valid <= |s_exp;
      err_mask  <= s_exp;
    end
  end
endmodule

// File: rtl/outreq_ctrl_chk.sv
module outreq_ctrl_chk
  import outreq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_posted,
  input logic              iss_valid,
  input logic              iss_take,
  input logic [SLOT_W-1:0] iss_slot,
  input logic [ADDR_W-1:0] iss_addr,
  input logic [LEN_W-1:0]  iss_len,
  input logic              rsp_need,
  input logic              err_valid,
  input logic [NSLOT-1:0]  err_mask,
  input logic              np_busy,
  input logic [NSLOT-1:0]  s_busy
);
  a_r1_full_blocks: assert property (@(posedge clk) disable iff (rst)
    (&s_busy) |-> !in_ready);

  a_r2_issue_hold: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && !iss_take) |=> (iss_valid && $stable(iss_slot) &&
                                  $stable(iss_addr) && $stable(iss_len)));

  a_r2_gap_after_take: assert property (@(posedge clk) disable iff (rst)
    (iss_valid && iss_take) |=> !iss_valid);

  a_r4_np_claims_entry: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !in_posted) |=> np_busy);

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_need |=> !rsp_need);

  a_r9_expired_is_free: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> ((s_busy & err_mask) == '0));
endmodule

bind outreq_ctrl outreq_ctrl_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_posted (in_posted),
  .iss_valid (iss_valid),
  .iss_take  (iss_take),
  .iss_slot  (iss_slot),
  .iss_addr  (iss_addr),
  .iss_len   (iss_len),
  .rsp_need  (rsp_need),
  .err_valid (err_valid),
  .err_mask  (err_mask),
  .np_busy   (np_busy),
  .s_busy    (s_busy)
);

// File: tb/outreq_ctrl_bench.sv
module outreq_ctrl_bench;
  localparam int AW = 32;
  localparam int LW = 12;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0, in_posted = 1'b1;
  logic [AW-1:0] in_addr = '0;
  logic [LW-1:0] in_len = '0;
  logic          in_ready;
  logic          iss_valid, iss_posted, iss_take = 1'b0;
  logic [0:0]    iss_slot;
  logic [AW-1:0] iss_addr;
  logic [LW-1:0] iss_len;
  logic [1:0]    st_valid = '0;
  logic [3:0]    st_kind = '0;
  logic [2*LW-1:0] st_moved = '0;
  logic [TW-1:0] tmr_limit = 16'd1000;
  logic          rsp_need, rsp_done = 1'b0, err_valid;
  logic [0:0]    rsp_slot;
  logic [1:0]    err_mask;

  int nchk = 0, nfail = 0, cyc = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  outreq_ctrl #(.ADDR_W(AW), .LEN_W(LW), .TMR_W(TW)) u_outreq_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_len(in_len), .in_posted(in_posted),
    .iss_valid(iss_valid), .iss_take(iss_take), .iss_slot(iss_slot),
    .iss_addr(iss_addr), .iss_len(iss_len), .iss_posted(iss_posted),
    .st_valid(st_valid), .st_kind(st_kind), .st_moved(st_moved),
    .tmr_limit(tmr_limit), .rsp_need(rsp_need), .rsp_slot(rsp_slot),
    .rsp_done(rsp_done), .err_valid(err_valid), .err_mask(err_mask)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_all();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  endtask

  task automatic push(input logic [AW-1:0] a, input logic [LW-1:0] l, input bit p);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_len = l; in_posted = p;
    #1;
    for (int n = 0; n < 20 && !in_ready; n++) begin
      @(negedge clk); #1;
    end
    @(negedge clk);
    in_valid = 1'b0; in_posted = 1'b1;
  endtask

  task automatic get_iss(input string req, input int eslot, input logic [AW-1:0] ea,
                         input logic [LW-1:0] el, input bit ep);
    for (int n = 0; n < 50 && !iss_valid; n++) @(negedge clk);
    chk(iss_valid && iss_slot == eslot[0], {req, " issue slot"}, {iss_valid, iss_slot}, {1'b1, eslot[0]});
    chk(iss_addr == ea && iss_len == el && iss_posted == ep, {req, " issue fields"},
        {iss_addr, iss_len}, {ea, el});
    iss_take = 1'b1;
    @(negedge clk);
    iss_take = 1'b0;
  endtask

  task automatic stat(input int s, input logic [1:0] k, input logic [LW-1:0] m,
                      output bit need, output bit nslot, output bit err);
    st_valid[s] = 1'b1; st_kind[2*s +: 2] = k; st_moved[LW*s +: LW] = m;
    @(negedge clk);
    st_valid = '0; st_kind = '0; st_moved = '0;
    need = rsp_need; nslot = rsp_slot; err = err_valid;
  endtask

  task automatic stat2(input logic [1:0] k);
    st_valid = 2'b11; st_kind = {k, k}; st_moved = '0;
    @(negedge clk);
    st_valid = '0; st_kind = '0;
  endtask

  initial begin
    #(8 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_all();
  end

  bit need, nsl, err;
  int c0;
  int m_st [2];
  logic [AW-1:0] m_addr [2];
  logic [LW-1:0] m_len [2];

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    in_posted = 1'b0;
    #1;
    // R1 reset state
    chk(in_ready && !iss_valid && !rsp_need && !err_valid, "R1 reset",
        {in_ready, iss_valid, rsp_need, err_valid}, 4'b1000);
    in_posted = 1'b1;

    // R1/R2: two posted requests fill slots 0 and 1
    push(32'h1000, 12'd64, 1'b1);
    push(32'h2000, 12'd32, 1'b1);
    get_iss("R2", 0, 32'h1000, 12'd64, 1'b1);
    get_iss("R2", 1, 32'h2000, 12'd32, 1'b1);
    chk(!iss_valid, "R2 gap", iss_valid, 0);
    in_valid = 1'b1; in_posted = 1'b1; #1;
    chk(!in_ready, "R1 full", in_ready, 0);
    in_valid = 1'b0;

    // R7 posted complete, R1 lowest free slot reuse
    stat(1, 2'b00, 0, need, nsl, err);
    chk(!need, "R7 no rsp", need, 0);
    push(32'h3000, 12'd16, 1'b1);
    get_iss("R1 slot reuse", 1, 32'h3000, 12'd16, 1'b1);

    // R5 retry unchanged
    stat(1, 2'b01, 12'd5, need, nsl, err);
    get_iss("R5", 1, 32'h3000, 12'd16, 1'b1);
    // R6 disconnect resumes
    stat(0, 2'b10, 12'd24, need, nsl, err);
    get_iss("R6", 0, 32'h1018, 12'd40, 1'b1);

    // R3 round robin: last issued 0, both retried -> 1 first
    stat2(2'b01);
    get_iss("R3 rr", 1, 32'h3000, 12'd16, 1'b1);
    get_iss("R3 rr", 0, 32'h1018, 12'd40, 1'b1);
    stat(1, 2'b01, 0, need, nsl, err);
    get_iss("R3 single", 1, 32'h3000, 12'd16, 1'b1);
    stat2(2'b01);
    get_iss("R3 rr", 0, 32'h1018, 12'd40, 1'b1);
    get_iss("R3 rr", 1, 32'h3000, 12'd16, 1'b1);
    stat(0, 2'b00, 0, need, nsl, err);
    stat(1, 2'b00, 0, need, nsl, err);
    chk(!need, "R7 no rsp", need, 0);

    // R4 / R8 non-posted entry
    push(32'h4000, 12'd8, 1'b0);
    get_iss("R8", 0, 32'h4000, 12'd8, 1'b0);
    in_posted = 1'b0; #1;
    chk(!in_ready, "R4 np blocked", in_ready, 0);
    in_posted = 1'b1; #1;
    chk(in_ready, "R4 posted open", in_ready, 1);
    stat(0, 2'b00, 0, need, nsl, err);
    chk(need && nsl == 1'b0, "R8 rsp pulse", {need, nsl}, 2'b10);
    @(negedge clk);
    chk(!rsp_need, "R8 pulse one cycle", rsp_need, 0);
    in_posted = 1'b0; #1;
    chk(!in_ready, "R8 entry held", in_ready, 0);
    @(negedge clk); rsp_done = 1'b1;
    @(negedge clk); rsp_done = 1'b0; #1;
    chk(in_ready, "R8 entry released", in_ready, 1);
    in_posted = 1'b1;

    // R10 ignored status and rsp_done
    stat(1, 2'b00, 0, need, nsl, err);
    chk(!need && !iss_valid, "R10 free slot status", {need, iss_valid}, 0);
    rsp_done = 1'b1; @(negedge clk); rsp_done = 1'b0;
    repeat (3) @(negedge clk);
    chk(!iss_valid && !rsp_need && in_ready, "R10 idle", {iss_valid, rsp_need, in_ready}, 3'b001);
    push(32'h5000, 12'd4, 1'b0);
    get_iss("R10", 0, 32'h5000, 12'd4, 1'b0);
    stat(0, 2'b11, 0, need, nsl, err);
    chk(!need && !err, "R10 reserved kind", need, 0);
    stat(0, 2'b00, 0, need, nsl, err);
    chk(need, "R10 slot still in flight", need, 1);
    rsp_done = 1'b1; @(negedge clk); rsp_done = 1'b0;

    // R9 timer not restarted by reissue
    tmr_limit = 16'd20;
    push(32'h6000, 12'd16, 1'b1);
    get_iss("R9", 0, 32'h6000, 12'd16, 1'b1);
    c0 = cyc;
    repeat (4) @(negedge clk);
    stat(0, 2'b01, 0, need, nsl, err);
    get_iss("R9 reissue", 0, 32'h6000, 12'd16, 1'b1);
    for (int n = 0; n < 100 && !err_valid; n++) @(negedge clk);
    chk(err_valid && (cyc - c0) == 21, "R9 expiry time", cyc - c0, 21);
    chk(err_mask == 2'b01, "R9 err mask", err_mask, 2'b01);

    // R9 non-posted expiry releases entry
    push(32'h7000, 12'd4, 1'b0);
    get_iss("R9 np", 0, 32'h7000, 12'd4, 1'b0);
    c0 = cyc;
    for (int n = 0; n < 100 && !err_valid; n++) @(negedge clk);
    chk(err_valid && (cyc - c0) == 21, "R9 np expiry time", cyc - c0, 21);
    in_posted = 1'b0; #1;
    chk(in_ready, "R9 entry released", in_ready, 1);
    in_posted = 1'b1;
    tmr_limit = 16'hFFFF;
    repeat (2) @(negedge clk);

    // random posted traffic: R1 R5 R6 R7
    for (int s = 0; s < 2; s++) begin m_st[s] = 0; m_addr[s] = '0; m_len[s] = '0; end
    for (int it = 0; it < 3000; it++) begin
      int took, fidx;
      bit exp_rdy;
      @(negedge clk);
      took = -1;
      if (iss_valid) begin
        chk(m_st[iss_slot] == 1 && iss_addr == m_addr[iss_slot] && iss_len == m_len[iss_slot],
            "R6 random issue", {iss_addr, iss_len}, {m_addr[iss_slot], m_len[iss_slot]});
        m_st[iss_slot] = 2;
        took = iss_slot;
        iss_take = 1'b1;
      end else iss_take = 1'b0;
      exp_rdy = (m_st[0] == 0) || (m_st[1] == 0);
      fidx = (m_st[0] == 0) ? 0 : 1;
      chk(in_ready == exp_rdy, "R1 random ready", in_ready, exp_rdy);
      in_valid = 1'b0;
      if (exp_rdy && ($urandom % 3 == 0)) begin
        in_valid = 1'b1; in_posted = 1'b1;
        in_addr = $urandom; in_len = LW'(1 + $urandom % 255);
        m_st[fidx] = 1; m_addr[fidx] = in_addr; m_len[fidx] = in_len;
      end
      st_valid = '0; st_kind = '0; st_moved = '0;
      for (int s = 0; s < 2; s++) begin
        if (m_st[s] == 2 && s != took && ($urandom % 4 == 0)) begin
          int k;
          k = $urandom % 3;
          st_valid[s] = 1'b1;
          if (k == 0) begin
            st_kind[2*s +: 2] = 2'b00; m_st[s] = 0;
          end else if (k == 2 && m_len[s] > 1) begin
            logic [LW-1:0] mv;
            mv = LW'(1 + $urandom % (m_len[s] - 1));
            st_kind[2*s +: 2] = 2'b10; st_moved[LW*s +: LW] = mv;
            m_addr[s] = m_addr[s] + AW'(mv); m_len[s] = m_len[s] - mv; m_st[s] = 1;
          end else begin
            st_kind[2*s +: 2] = 2'b01; m_st[s] = 1;
          end
        end
      end
    end
    @(negedge clk);
    in_valid = 1'b0; iss_take = 1'b0; st_valid = '0;
    repeat (3) @(negedge clk);
    finish_all();
  end
endmodule